// File: doc/BRIEF.md
# Vectored Interrupt Address Generator

This block sits beside a small processor core and decides which pending interrupt the core takes next, then hands the core the address to continue from. Ten maskable requests are latched as pending flags: external line 0 and nine vectored sources (external lines 1 and 2, two timer channels, two DMA channels, a clocked serial port and two async serial channels). A non-maskable trap strobe, raised when the core fetches an undefined opcode, comes in on its own input. Once a request is accepted, the block emits a one-cycle acknowledge. The acknowledge carries the winning source index, an address and a kind code. The kind code tells the core whether the address is a table entry to read, a direct restart address, or whether it must instead fetch an opcode byte from the data bus.

The vectored sources share a 16-entry table of 2-byte entries. Its base is built from an 8-bit vector-page register and a 3-bit table-select register, so it always lies on a 32-byte boundary. Line 0 can use one of three response modes. In the bus-opcode mode the core fetches an instruction byte from the data bus. In the fixed-restart mode the block gives address 0x0038. In the paged-table mode the block waits one cycle, samples the data bus, and builds the address from the page register (high byte) and the sampled byte (low byte). A trap restarts at address 0. It also sets a sticky trap flag and a byte-position flag, which software uses to correct the stacked PC.

The controller is a three-state machine:
- ST_IDLE: arbitrates.
- ST_BUSRD: samples the data bus for paged-table line 0.
- ST_ACK: drives the acknowledge.

Its transitions are:
- IDLE→ACK: a trap is pending, or a maskable request is accepted in any case other than paged-table line 0.
- IDLE→BUSRD: line 0 is accepted in paged-table mode.
- BUSRD→ACK: always.
- ACK→IDLE: always.
- IDLE→IDLE: nothing is eligible.

Top module: `irq_vector_unit`

## Requirements
- R1: Synchronous active-high reset clears the acknowledge, the trap flag, the byte-position flag, the page register and the table-select register, and selects bus-opcode mode (0) for line 0.
- R2: A vectored source on `irq_in` bit k (k = 1..9, in the order line 1, line 2, timer 0, timer 1, DMA 0, DMA 1, serial, async 0, async 1) is acknowledged with kind 0 (table) and address page*256 + select*32 + 2*(k-1).
- R3: When several requests are eligible, the trap wins first, then `irq_in` bit 0, then bits 1 to 9 in ascending order. The losers stay pending and are served one by one afterwards.
- R4: A maskable request is accepted only while `glob_ie` is high and its `irq_en` bit is set. Until then it stays pending and no acknowledge appears. The trap ignores both inputs.
- R5: Line 0 in fixed-restart mode (mode code 1) is acknowledged with kind 1 (restart) and address 0x0038.
- R6: Line 0 in paged-table mode (mode code 2) is acknowledged one cycle later than other sources, with kind 0 and address page*256 + the `bus_data` byte sampled in the cycle after acceptance.
- R7: Line 0 in bus-opcode mode (mode code 0) is acknowledged with kind 2 (bus opcode) and address 0.
- R8: A trap is acknowledged with source index 10, kind 1 and address 0. It sets `trap_flag`, and it loads `ufo_flag` with the `trap_byte` value captured with the strobe (0 = second opcode byte, 1 = third).
- R9: Writing register 3 with bit 0 equal to 0 clears `trap_flag`. Writing it with bit 0 equal to 1 has no effect.
- R10: Each accepted request gives exactly one acknowledge, high for one cycle. It appears two clock edges after the request strobe is sampled, and the request's pending flag is cleared.
- R11: Register writes select by `reg_addr`: 0 is the page (bits 7:0), 1 is the table select (bits 2:0), and 2 is the line 0 mode (bits 1:0). A mode write of 3 is ignored and leaves the previous mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 10 | Request strobes; bit 0 is line 0, bits 1..9 the vectored sources |
| irq_en | input | 10 | Per-source enables for the maskable requests |
| glob_ie | input | 1 | Global enable for maskable requests |
| trap_req | input | 1 | Undefined-opcode trap strobe |
| trap_byte | input | 1 | Opcode byte that faulted: 0 second, 1 third |
| bus_data | input | 8 | Data-bus byte, sampled for paged-table line 0 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| ack | output | 1 | One-cycle acknowledge |
| ack_src | output | 4 | Source index of the acknowledge (10 = trap) |
| ack_kind | output | 2 | 0 table entry, 1 direct restart, 2 bus opcode |
| ack_addr | output | 16 | Table or restart address |
| trap_flag | output | 1 | Sticky trap status |
| ufo_flag | output | 1 | Faulting byte position of the last trap |

## Verification
The trap path and maskable arbitration can both fire in the same cycle. The bench provokes this by pulsing `trap_req` together with a line 1 request while both are eligible. It requires the trap acknowledge first, with its flags set, and the line 1 acknowledge exactly two cycles later. The trap is also raised while a maskable request is held off by `glob_ie`. The bench then checks that the trap is served alone and that the held request follows as soon as the enable rises.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [1:0] {
        KIND_TABLE   = 2'd0,
        KIND_RESTART = 2'd1,
        KIND_BUSOP   = 2'd2
    } ack_kind_e;

    typedef enum logic [1:0] {
        L0_BUSOP = 2'd0,
        L0_FIXED = 2'd1,
        L0_PAGED = 2'd2
    } l0_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSRD = 2'd1,
        ST_ACK   = 2'd2
    } vec_state_e;

    localparam logic [1:0] REG_PAGE = 2'd0;
    localparam logic [1:0] REG_SEL  = 2'd1;
    localparam logic [1:0] REG_MODE = 2'd2;
    localparam logic [1:0] REG_TRAP = 2'd3;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int NSRC = 10,
    parameter int IW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            gie,
    input  logic            take,
    output logic            any_ok,
    output logic [IW-1:0]   win
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] clr;

    assign elig   = pend_q & en & {NSRC{gie}};
    assign any_ok = |elig;

    // lowest index wins
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) win = IW'(i);
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        assign clr[g] = take && (win == IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | req;
    end
endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
    import irq_vec_pkg::*;
#(
    parameter int IREG_W = 8,
    parameter int IL_W   = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trap_set,
    input  logic              trap_pos,
    output logic [IREG_W-1:0] page,
    output logic [IL_W-1:0]   tsel,
    output l0_mode_e          mode,
    output logic              trap_flag,
    output logic              ufo_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            tsel <= '0;
            mode <= L0_BUSOP;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_PAGE: page <= wr_data[IREG_W-1:0];
                REG_SEL:  tsel <= wr_data[IL_W-1:0];
                REG_MODE: if (wr_data[1:0] != 2'd3) mode <= l0_mode_e'(wr_data[1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_flag <= 1'b0;
            ufo_flag  <= 1'b0;
        end else if (trap_set) begin
            trap_flag <= 1'b1;
            ufo_flag  <= trap_pos;
        end else if (wr_en && wr_sel == REG_TRAP && !wr_data[0]) begin
            trap_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_addr.sv
module irq_addr
    import irq_vec_pkg::*;
#(
    parameter int IREG_W = 8,
    parameter int IL_W   = 3,
    parameter int OFF_W  = 5,
    parameter int SRC_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic [SRC_W-1:0]  src,
    input  logic [IREG_W-1:0] page,
    input  logic [IL_W-1:0]   tsel,
    input  l0_mode_e          mode,
    output logic [ADDR_W-1:0] addr,
    output ack_kind_e         kind
);
    localparam logic [ADDR_W-1:0] FIXED_RESTART = ADDR_W'(16'h0038);

    logic [SRC_W-1:0] slot;
    logic [OFF_W-1:0] off;

    assign slot = src - SRC_W'(1);
    assign off  = OFF_W'({slot, 1'b0});

    always_comb begin
        addr = {page, tsel, off};
        kind = KIND_TABLE;
        if (src == '0) begin
            unique case (mode)
                L0_FIXED: begin addr = FIXED_RESTART; kind = KIND_RESTART; end
                L0_BUSOP: begin addr = '0;            kind = KIND_BUSOP;   end
                default:  begin addr = '0;            kind = KIND_TABLE;   end
            endcase
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_vec_pkg::*;
#(
    parameter int NUM_VSRC = 9,
    parameter int IREG_W   = 8,
    parameter int IL_W     = 3,
    parameter int OFF_W    = 5,
    parameter int BUS_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_VSRC:0]                 irq_in,
    input  logic [NUM_VSRC:0]                 irq_en,
    input  logic                              glob_ie,
    input  logic                              trap_req,
    input  logic                              trap_byte,
    input  logic [BUS_W-1:0]                  bus_data,
    input  logic                              reg_we,
    input  logic [1:0]                        reg_addr,
    input  logic [IREG_W-1:0]                 reg_wdata,
    output logic                              ack,
    output logic [$clog2(NUM_VSRC+2)-1:0]     ack_src,
    output logic [1:0]                        ack_kind,
    output logic [IREG_W+IL_W+OFF_W-1:0]      ack_addr,
    output logic                              trap_flag,
    output logic                              ufo_flag
);
    localparam int NSRC    = NUM_VSRC + 1;
    localparam int SRC_W   = $clog2(NUM_VSRC + 2);
    localparam int ADDR_W  = IREG_W + IL_W + OFF_W;
    localparam int TRAP_ID = NUM_VSRC + 1;

    vec_state_e st_q, st_d;

    logic              trap_pend_q, trap_pos_q;
    logic              take_trap, take_src;
    logic              any_ok;
    logic [SRC_W-1:0]  win;
    logic [IREG_W-1:0] page;
    logic [IL_W-1:0]   tsel;
    l0_mode_e          mode;
    logic [ADDR_W-1:0] gen_addr;
    ack_kind_e         gen_kind;

    logic [SRC_W-1:0]  src_q;
    ack_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;

    irq_pend #(.NSRC(NSRC), .IW(SRC_W)) u_pend (
        .clk(clk), .rst(rst), .req(irq_in), .en(irq_en), .gie(glob_ie),
        .take(take_src), .any_ok(any_ok), .win(win)
    );

    irq_cfg #(.IREG_W(IREG_W), .IL_W(IL_W), .DATA_W(IREG_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(reg_we), .wr_sel(reg_addr),
        .wr_data(reg_wdata), .trap_set(take_trap), .trap_pos(trap_pos_q),
        .page(page), .tsel(tsel), .mode(mode),
        .trap_flag(trap_flag), .ufo_flag(ufo_flag)
    );

    irq_addr #(.IREG_W(IREG_W), .IL_W(IL_W), .OFF_W(OFF_W),
               .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_addr (
        .src(win), .page(page), .tsel(tsel), .mode(mode),
        .addr(gen_addr), .kind(gen_kind)
    );

    // trap strobe is latched until served
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_pend_q <= 1'b0;
            trap_pos_q  <= 1'b0;
        end else begin
            trap_pend_q <= (trap_pend_q & ~take_trap) | trap_req;
            if (trap_req) trap_pos_q <= trap_byte;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state and acceptance
    always_comb begin
        st_d      = st_q;
        take_trap = 1'b0;
        take_src  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (trap_pend_q) begin
                    take_trap = 1'b1;
                    st_d      = ST_ACK;
                end else if (any_ok) begin
                    take_src = 1'b1;
                    st_d     = (win == '0 && mode == L0_PAGED) ? ST_BUSRD : ST_ACK;
                end
            end
            ST_BUSRD: st_d = ST_ACK;
            ST_ACK:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // selection capture
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            kind_q <= KIND_TABLE;
            addr_q <= '0;
        end else if (take_trap) begin
            src_q  <= SRC_W'(TRAP_ID);
            kind_q <= KIND_RESTART;
            addr_q <= '0;
        end else if (take_src) begin
            src_q  <= win;
            kind_q <= gen_kind;
            addr_q <= gen_addr;
        end else if (st_q == ST_BUSRD) begin
            addr_q <= ADDR_W'({page, bus_data});
        end
    end

    // outputs
    always_comb begin
        ack      = (st_q == ST_ACK);
        ack_src  = ack ? src_q  : '0;
        ack_kind = ack ? kind_q : 2'd0;
        ack_addr = ack ? addr_q : '0;
    end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
    parameter int SRC_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 5,
    parameter int TRAP_ID = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic [SRC_W-1:0]  ack_src,
    input logic [1:0]        ack_kind,
    input logic [ADDR_W-1:0] ack_addr,
    input logic              trap_flag,
    input logic              glob_ie,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic              clr_bit
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ack && !trap_flag));

    p_table_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_kind == 2'd0 && ack_src != '0) |->
        (ack_addr[OFF_W-1:0] == OFF_W'((ack_src - SRC_W'(1)) * 2)));

    p_gie_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_src != SRC_W'(TRAP_ID) && !(ack_src == '0 && ack_kind == 2'd0))
        |-> $past(glob_ie));

    p_fixed_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_src == '0 && ack_kind == 2'd1) |-> ack_addr == ADDR_W'(16'h0038));

    p_busop_r7: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_kind == 2'd2) |-> (ack_src == '0 && ack_addr == '0));

    p_trap_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_src == SRC_W'(TRAP_ID)) |-> (ack_addr == '0 && trap_flag && ack_kind == 2'd1));

    p_trap_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (trap_flag && !(reg_we && reg_addr == 2'd3 && !clr_bit)) |=> trap_flag);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
    .SRC_W(SRC_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TRAP_ID(TRAP_ID)
) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .ack_src(ack_src), .ack_kind(ack_kind),
    .ack_addr(ack_addr), .trap_flag(trap_flag), .glob_ie(glob_ie),
    .reg_we(reg_we), .reg_addr(reg_addr), .clr_bit(reg_wdata[0])
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  irq_in = '0;
    logic [9:0]  irq_en = '1;
    logic        glob_ie = 1'b1;
    logic        trap_req = 1'b0;
    logic        trap_byte = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        ack;
    logic [3:0]  ack_src;
    logic [1:0]  ack_kind;
    logic [15:0] ack_addr;
    logic        trap_flag, ufo_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_page = 0;
    int cur_sel = 0;

    irq_vector_unit uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_en(irq_en), .glob_ie(glob_ie),
        .trap_req(trap_req), .trap_byte(trap_byte), .bus_data(bus_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ack(ack), .ack_src(ack_src), .ack_kind(ack_kind), .ack_addr(ack_addr),
        .trap_flag(trap_flag), .ufo_flag(ufo_flag)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int vaddr(input int k);
        return cur_page * 256 + cur_sel * 32 + 2 * (k - 1);
    endfunction

    function automatic int l0_or_vec(input int k);
        return (k == 0) ? 32'h38 : vaddr(k);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [9:0] v, input logic t, input logic tb);
        irq_in = v; trap_req = t; trap_byte = tb;
        @(negedge clk);
        irq_in = '0; trap_req = 1'b0;
    endtask

    task automatic expect_ack(input string req, input int src, input int kind, input int addr);
        check(req, "ack", int'(ack), 1);
        check(req, "src", int'(ack_src), src);
        check(req, "kind", int'(ack_kind), kind);
        check(req, "addr", int'(ack_addr), addr);
        @(negedge clk);
        check(req, "ack falls", int'(ack), 0);
    endtask

    task automatic expect_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, "no ack", int'(ack), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ack", int'(ack), 0);
        check("R1", "trap_flag", int'(trap_flag), 0);
        check("R1", "ufo_flag", int'(ufo_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: page/select zero, line 0 in bus-opcode mode
        pulse(10'b10, 0, 0); @(negedge clk);
        expect_ack("R1", 1, 0, 0);
        pulse(10'b1, 0, 0); @(negedge clk);
        expect_ack("R7", 0, 2, 0);
        expect_quiet("R10", 3);

        // R2 sweep: page values x every select x every vectored source
        for (int p = 0; p < 3; p++) begin
            cur_page = (p == 0) ? 0 : (p == 1) ? 8'h5A : 8'hFF;
            wr(2'd0, 8'(cur_page));
            for (int s = 0; s < 8; s++) begin
                cur_sel = s;
                wr(2'd1, 8'(s));
                for (int k = 1; k < 10; k++) begin
                    pulse(10'(1 << k), 0, 0); @(negedge clk);
                    expect_ack("R2", k, 0, vaddr(k));
                end
            end
        end

        // R3 pairwise priority, line 0 in fixed mode (R5)
        wr(2'd2, 8'd1);
        for (int a = 0; a < 9; a++) begin
            for (int b = a + 1; b < 10; b++) begin
                pulse(10'((1 << a) | (1 << b)), 0, 0); @(negedge clk);
                expect_ack("R3", a, (a == 0) ? 1 : 0, l0_or_vec(a));
                @(negedge clk);
                expect_ack("R3", b, 0, vaddr(b));
            end
        end
        pulse(10'b1, 0, 0); @(negedge clk);
        expect_ack("R5", 0, 1, 32'h38);

        // R11: mode code 3 ignored
        wr(2'd2, 8'd3);
        pulse(10'b1, 0, 0); @(negedge clk);
        expect_ack("R11", 0, 1, 32'h38);

        // R4 per-source enable
        irq_en = 10'h3FF & ~10'(1 << 5);
        pulse(10'(1 << 5), 0, 0);
        expect_quiet("R4", 4);
        irq_en = '1;
        @(negedge clk);
        expect_ack("R4", 5, 0, vaddr(5));

        // R4 global enable held low; trap still served (R8)
        glob_ie = 1'b0;
        pulse(10'b100, 0, 0);
        expect_quiet("R4", 3);
        pulse(10'b0, 1, 1); @(negedge clk);
        expect_ack("R8", 10, 1, 0);
        check("R8", "trap_flag", int'(trap_flag), 1);
        check("R8", "ufo_flag", int'(ufo_flag), 1);
        expect_quiet("R4", 2);
        glob_ie = 1'b1;
        @(negedge clk);
        expect_ack("R4", 2, 0, vaddr(2));

        // R9 trap flag write semantics
        wr(2'd3, 8'h01);
        check("R9", "trap_flag after write 1", int'(trap_flag), 1);
        wr(2'd3, 8'h00);
        check("R9", "trap_flag after write 0", int'(trap_flag), 0);

        // R3 trap and line 1 together
        pulse(10'b10, 1, 0); @(negedge clk);
        expect_ack("R3", 10, 1, 0);
        check("R8", "ufo_flag", int'(ufo_flag), 0);
        check("R8", "trap_flag", int'(trap_flag), 1);
        @(negedge clk);
        expect_ack("R3", 1, 0, vaddr(1));

        // R6 paged mode for line 0
        wr(2'd2, 8'd2);
        cur_page = 8'h3C;
        wr(2'd0, 8'h3C);
        bus_data = 8'hA4;
        pulse(10'b1, 0, 0); @(negedge clk);
        check("R6", "no ack yet", int'(ack), 0);
        @(negedge clk);
        expect_ack("R6", 0, 0, 16'h3CA4);
        bus_data = 8'h07;
        pulse(10'b1, 0, 0); @(negedge clk); @(negedge clk);
        expect_ack("R6", 0, 0, 16'h3C07);

        // R7 bus-opcode mode again
        wr(2'd2, 8'd0);
        pulse(10'b1, 0, 0); @(negedge clk);
        expect_ack("R7", 0, 2, 0);
        expect_quiet("R10", 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule